// File: doc/BRIEF.md
# USB PHY Wake-up and Safe-Mode Controller

This block sits between a host register bus and a low-pin-count USB PHY port. It keeps one small 32-bit control word holding three software enables and one sticky wake-up status flag. While the port is in low power (its PHY clock-disable control is set), it turns asynchronous wake-up events into a masked, registered interrupt line.

Two sources can signal a wake-up. The first is a system wake-up event. The second is a PHY-originated wakeup, which counts only when its own enable is set. The status flag stays set until software takes the port out of low power. Writes to the flag itself have no effect on it.

The same word also holds an interface enable. While that enable is clear, the block is in safe mode: it holds the PHY-facing pins at fixed levels and shows the controller an asserted direction input. This keeps the controller and the PHY from disturbing each other while either one is still coming out of reset.

Top module: `usbphy_wake_ctl`

## Requirements
- R1: After reset the control word reads 0x00000000, `irq` is 0 and the block is in safe mode.
- R2: Only bit 0 (PHY wakeup enable), bit 1 (interrupt enable), bit 2 (interface enable) and bit 16 (wake status) can read as 1. All other bits read 0, and writing them has no effect.
- R3: A rising edge on `wake_evt` while `low_power` is 1 sets bit 16. The edge passes through two synchronising flops and an edge-detect flop, so bit 16 reads 1 three clocks after the input rises.
- R4: Once set, bit 16 stays 1 while `low_power` stays 1, whatever is written to the word.
- R5: A clock edge that samples `low_power` as 0 leaves bit 16 at 0.
- R6: A wake-up edge that arrives while `low_power` is 0 does not set bit 16.
- R7: `irq` is a registered level: it equals bit 16 AND bit 1 as they stood one clock earlier. With bit 1 clear, `irq` stays 0.
- R8: A rising edge on `phy_wake` sets bit 16 only when bit 0 and `low_power` are both 1. The timing is the same as for R3.
- R9: With bit 2 clear (safe mode), the outputs take fixed values: `phy_stp` is 1, `phy_dout` is 0, `phy_oe` is 0, `ctl_dir` is 1 and `ctl_nxt` is 0.
- R10: With bit 2 set, `phy_stp`, `phy_dout` and `phy_oe` follow the controller-side inputs, and `ctl_dir` and `ctl_nxt` follow the PHY pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| low_power | input | 1 | PHY clock-disable (low-power) control |
| wake_evt | input | 1 | Asynchronous system wake-up event |
| phy_wake | input | 1 | Asynchronous PHY-originated wakeup |
| irq | output | 1 | System wake-up interrupt |
| ctl_stp | input | 1 | Stop signal from the controller |
| ctl_dout | input | DATA_W | Data from the controller toward the PHY |
| ctl_oe | input | 1 | Output enable from the controller |
| phy_dir | input | 1 | Direction pin from the PHY |
| phy_nxt | input | 1 | Next pin from the PHY |
| phy_stp | output | 1 | Stop pin toward the PHY |
| phy_dout | output | DATA_W | Data pins toward the PHY |
| phy_oe | output | 1 | Data pin output enable |
| ctl_dir | output | 1 | Direction as seen by the controller |
| ctl_nxt | output | 1 | Next as seen by the controller |

## Verification
The bench uses the default parameters: an 8-bit data path and a two-stage synchroniser. With those values the three-clock latency from event to status, and the fourth clock for `irq`, can be checked exactly on every cycle. The 8-bit path also lets the bench show that every data bit is forced to 0 in safe mode and passes through unchanged in normal mode. Wake-up pulses are applied in and out of low power, with each enable set and clear, so the status and interrupt are compared cycle by cycle against a behavioural model.

// File: rtl/usbphy_wake_ctl.sv
module usbphy_wake_ctl #(
  parameter int DATA_W = 8,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              low_power,
  input  logic              wake_evt,
  input  logic              phy_wake,
  output logic              irq,
  input  logic              ctl_stp,
  input  logic [DATA_W-1:0] ctl_dout,
  input  logic              ctl_oe,
  input  logic              phy_dir,
  input  logic              phy_nxt,
  output logic              phy_stp,
  output logic [DATA_W-1:0] phy_dout,
  output logic              phy_oe,
  output logic              ctl_dir,
  output logic              ctl_nxt
);
  localparam int B_PWEN = 0;
  localparam int B_IREN = 1;
  localparam int B_IFEN = 2;
  localparam int B_STAT = 16;

  logic            pw_en, ir_en, if_en, status;
  logic [SYNC_W:0] ev_sh, pw_sh;
  logic            ev_rise, pw_rise, set_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_sh <= '0;
      pw_sh <= '0;
    end else begin
      ev_sh <= {ev_sh[SYNC_W-1:0], wake_evt};
      pw_sh <= {pw_sh[SYNC_W-1:0], phy_wake};
    end
  end

  assign ev_rise  = ev_sh[SYNC_W-1] & ~ev_sh[SYNC_W];
  assign pw_rise  = pw_sh[SYNC_W-1] & ~pw_sh[SYNC_W];
  assign set_stat = ev_rise | (pw_rise & pw_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_en  <= 1'b0;
      ir_en  <= 1'b0;
      if_en  <= 1'b0;
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (reg_we) begin
        pw_en <= reg_wdata[B_PWEN];
        ir_en <= reg_wdata[B_IREN];
        if_en <= reg_wdata[B_IFEN];
      end
      status <= low_power & (status | set_stat);
      irq    <= status & ir_en;
    end
  end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[B_PWEN] = pw_en;
    reg_rdata[B_IREN] = ir_en;
    reg_rdata[B_IFEN] = if_en;
    reg_rdata[B_STAT] = status;
  end

  assign phy_stp  = if_en ? ctl_stp  : 1'b1;
  assign phy_dout = if_en ? ctl_dout : '0;
  assign phy_oe   = if_en & ctl_oe;
  assign ctl_dir  = if_en ? phy_dir  : 1'b1;
  assign ctl_nxt  = if_en & phy_nxt;
endmodule

module usbphy_wake_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       reg_rdata,
  input logic              low_power,
  input logic              irq,
  input logic              ctl_stp,
  input logic [DATA_W-1:0] ctl_dout,
  input logic              phy_dir,
  input logic              phy_stp,
  input logic [DATA_W-1:0] phy_dout,
  input logic              phy_oe,
  input logic              ctl_dir
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:17] == '0 && reg_rdata[15:3] == '0);
  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && reg_rdata[16]) |=> reg_rdata[16]);
  p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power |=> !reg_rdata[16]);
  p_set_in_lp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[16]) |-> $past(low_power));
  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[16] && reg_rdata[1]) |=> irq);
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rdata[16] && reg_rdata[1]) |=> !irq);
  p_safe_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[2] |-> (phy_stp && ctl_dir && !phy_oe && phy_dout == '0));
  p_pass_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[2] |-> (phy_stp == ctl_stp && ctl_dir == phy_dir && phy_dout == ctl_dout));
endmodule

bind usbphy_wake_ctl usbphy_wake_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .low_power(low_power),
  .irq(irq), .ctl_stp(ctl_stp), .ctl_dout(ctl_dout), .phy_dir(phy_dir),
  .phy_stp(phy_stp), .phy_dout(phy_dout), .phy_oe(phy_oe), .ctl_dir(ctl_dir)
);

// File: tb/test_usbphy_wake_ctl.sv
module test_usbphy_wake_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic low_power = 1'b0, wake_evt = 1'b0, phy_wake = 1'b0;
  logic irq;
  logic ctl_stp = 1'b0, ctl_oe = 1'b0, phy_dir = 1'b0, phy_nxt = 1'b0;
  logic [7:0] ctl_dout = '0, phy_dout;
  logic phy_stp, phy_oe, ctl_dir, ctl_nxt;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  usbphy_wake_ctl i_usbphy_wake_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .low_power(low_power), .wake_evt(wake_evt),
    .phy_wake(phy_wake), .irq(irq), .ctl_stp(ctl_stp), .ctl_dout(ctl_dout),
    .ctl_oe(ctl_oe), .phy_dir(phy_dir), .phy_nxt(phy_nxt), .phy_stp(phy_stp),
    .phy_dout(phy_dout), .phy_oe(phy_oe), .ctl_dir(ctl_dir), .ctl_nxt(ctl_nxt)
  );

  // behavioural reference: input sample histories and model state
  int ev_h[$], pw_h[$];
  int m_ctl = 0, m_stat = 0, m_irq = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ev_h = '{0, 0, 0}; pw_h = '{0, 0, 0};
      m_ctl = 0; m_stat = 0; m_irq = 0;
    end else begin
      int ev_set, pw_set;
      ev_set = (ev_h[1] == 1 && ev_h[2] == 0);
      pw_set = (pw_h[1] == 1 && pw_h[2] == 0) && (m_ctl & 1);
      m_irq  = m_stat && ((m_ctl >> 1) & 1);
      m_stat = low_power && (m_stat || ev_set || pw_set);
      if (reg_we) m_ctl = reg_wdata & 7;
      void'(ev_h.pop_back()); ev_h.push_front(int'(wake_evt));
      void'(pw_h.pop_back()); pw_h.push_front(int'(phy_wake));
    end
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    logic en;
    @(negedge clk);
    en = m_ctl[2];
    chk("R3 rdata", reg_rdata, (m_stat << 16) | m_ctl);
    chk("R7 irq", {31'b0, irq}, m_irq);
    chk(en ? "R10 pins" : "R9 pins",
        {phy_stp, phy_oe, ctl_dir, ctl_nxt, phy_dout},
        en ? {ctl_stp, ctl_oe, phy_dir, phy_nxt, ctl_dout}
           : {1'b1, 1'b0, 1'b1, 1'b0, 8'h00});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic pulse_ev();
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
  endtask

  task automatic pulse_pw();
    phy_wake = 1'b1; step(); phy_wake = 1'b0;
  endtask

  initial begin
    ctl_stp = 1'b0; ctl_oe = 1'b1; ctl_dout = 8'hA5; phy_dir = 1'b0; phy_nxt = 1'b1;
    run(3);
    chk("R1 reset rdata", reg_rdata, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    run(2);
    chk("R9 safe stp/dir", {30'b0, phy_stp, ctl_dir}, 32'h3);
    wr(32'hFFFF_FFFF);
    chk("R2 reserved write", reg_rdata, 32'h0000_0007);
    run(2);
    wr(32'h0000_0002);
    low_power = 1'b1;
    pulse_ev();
    run(1);
    chk("R3 not yet set", {31'b0, reg_rdata[16]}, 32'h0);
    run(1);
    chk("R3 status set", {31'b0, reg_rdata[16]}, 32'h1);
    run(1);
    chk("R7 irq raised", {31'b0, irq}, 32'h1);
    wr(32'h0000_0000);
    run(2);
    chk("R4 status sticky", {31'b0, reg_rdata[16]}, 32'h1);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    low_power = 1'b0;
    run(2);
    chk("R5 status cleared", {31'b0, reg_rdata[16]}, 32'h0);
    wr(32'h0000_0003);
    pulse_ev();
    run(5);
    chk("R6 event outside low power", reg_rdata, 32'h0000_0003);
    wr(32'h0000_0002);
    low_power = 1'b1;
    pulse_pw();
    run(5);
    chk("R8 phy wake disabled", {31'b0, reg_rdata[16]}, 32'h0);
    wr(32'h0000_0003);
    pulse_pw();
    run(5);
    chk("R8 phy wake enabled", {31'b0, reg_rdata[16]}, 32'h1);
    low_power = 1'b0;
    run(2);
    wr(32'h0000_0004);
    for (int i = 0; i < 40; i++) begin
      ctl_stp = i[0]; ctl_oe = i[1]; phy_dir = i[2]; phy_nxt = i[3];
      ctl_dout = 8'(i * 37 + 11);
      step();
    end
    chk("R10 data pass", {24'b0, phy_dout}, {24'b0, ctl_dout});
    wr(32'h0000_0000);
    chk("R9 safe data", {24'b0, phy_dout}, 32'h0);
    for (int i = 0; i < 30; i++) begin
      wake_evt = i[2]; phy_wake = i[1]; low_power = (i % 7) != 0;
      if (i == 10) reg_we = 1'b1; else reg_we = 1'b0;
      reg_wdata = 32'h0000_0003;
      step();
    end
    reg_we = 1'b0;
    run(4);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule